// File: doc/BRIEF.md
# System Controller Register File

This block is the software-visible register file of a system-controller chip. A processor reaches it through a simple synchronous bus: one access per valid cycle, with a 14-bit offset and a size code for byte, halfword or word. Read data comes back registered in the following cycle. Writes narrower than a word are merged into the live contents of the addressed word.

The file holds the following registers:
- a global configuration word
- the base and limit of the DMA translation table
- two tag registers, a data window and a byte-mask register for the I/O cache
- a row of fifteen remote-device speed registers
- a bank of eight DMA channels with four words each
- a few auxiliary words, some of which are read-only constants

All of these are plain storage. No DMA transfer, cache lookup or memory traffic happens here. There are two exceptions to plain storage. The cache byte-mask register accumulates writes by OR and clears itself when it is read back as all ones. The interval-timer reload and count locations drive single-cycle strobes out to a separate timer.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset:
  - the configuration word (offset 0x000) reads 0x104, which is RAM-size code 1 in bits 9:8 plus bit 2.
  - offset 0x210 reads 0x18186.
  - offsets 0x220 and 0x238 read 7.
  - every remote-speed register reads 7.
  - every other mapped word reads 0.
- R2: Register selection uses the offset with bits 1:0 cleared. Remote-speed register n (n = 0..14) is at offset 0x070 + 8n. The words at 0x074 + 8n are unmapped.
- R3: DMA word r (0..3) of channel c (0..7) is at offset 0x100 + 32c + 8r. The words at those offsets plus 4 are unmapped.
- R4: Read data appears on `bus_rdata` in the cycle after the read and holds until the next read. The size code is 0 for byte, 1 for halfword, and 2 or 3 for word.
  - A byte read returns lane `bus_addr[1:0]` zero-extended.
  - A halfword read returns bits 31:16 when `bus_addr[1]` is 1, and bits 15:0 otherwise.
- R5: A byte write replaces only bits 8k+7:8k of the addressed word, where k is `bus_addr[1:0]`. A halfword write replaces bits 31:16 when `bus_addr[1]` is 1, and bits 15:0 otherwise. Other bits are kept.
- R6: A write to the byte-mask register (0x058) ORs the merged write word into its current value.
- R7: A read of 0x058 returns the current value. If that value was all ones, the register is zero afterwards. Any other value is left unchanged.
- R8: Reads of unmapped offsets return 0, including every offset from 0x240 upward. Writes to unmapped offsets have no effect. Writes to the read-only words 0x010, 0x038 and 0x040 (which read 0), 0x208 (which reads 0) and 0x220 and 0x238 (which read 7) have no effect.
- R9: A write to 0x228 raises `tmr_load_stb` for exactly the next cycle, with `tmr_load_val` set to the write merged into zero. Reads of 0x228 return 0.
- R10: A read of 0x230 returns 0 and raises `tmr_count_stb` for exactly the next cycle. No other access raises it.
- R11: The words 0x000, 0x018, 0x020, 0x048, 0x050, 0x060 and 0x210, and the speed and DMA words, read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_addr | input | 14 | Byte offset into the register space |
| bus_wdata | input | 32 | Write data, right-aligned for narrow writes |
| bus_rdata | output | 32 | Registered read data |
| tmr_load_stb | output | 1 | Pulse after a write to the timer reload word |
| tmr_load_val | output | 32 | Value written to the timer reload word |
| tmr_count_stb | output | 1 | Pulse after a read of the timer count word |

## Verification
The hardest state to reach is the byte-mask register at exactly all ones. Only OR-accumulating writes can get it there, and the first read-back destroys it. The stimulus builds the value from separate narrow and full writes, then reads it twice: the first read must return all ones and the second must return zero. A partial mask is also read twice, to show that it survives a read. Full sweeps of every word offset, after reset and after a patterned write pass, cover the distinction between mapped and unmapped words, including the odd-word gaps inside the speed row and the DMA bank.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WORD_W = 32;

  // word offsets of singly placed registers
  localparam int unsigned OFS_CFG      = 'h000;
  localparam int unsigned OFS_BADADDR  = 'h010;
  localparam int unsigned OFS_XL_BASE  = 'h018;
  localparam int unsigned OFS_XL_LIM   = 'h020;
  localparam int unsigned OFS_RMT_FAIL = 'h038;
  localparam int unsigned OFS_MEM_FAIL = 'h040;
  localparam int unsigned OFS_PTAG     = 'h048;
  localparam int unsigned OFS_LTAG     = 'h050;
  localparam int unsigned OFS_BMASK    = 'h058;
  localparam int unsigned OFS_WINDOW   = 'h060;
  localparam int unsigned OFS_AUX_RO0  = 'h208;
  localparam int unsigned OFS_AUX_RW   = 'h210;
  localparam int unsigned OFS_NV_GUARD = 'h220;
  localparam int unsigned OFS_TMR_LOAD = 'h228;
  localparam int unsigned OFS_TMR_CNT  = 'h230;
  localparam int unsigned OFS_AUX_RO1  = 'h238;
  localparam int unsigned SPEED_BASE   = 'h070;
  localparam int unsigned DMA_BASE     = 'h100;

  localparam logic [1:0]        RAM_SZ_CODE = 2'd1;
  localparam logic [WORD_W-1:0] CFG_RST     = (32'(RAM_SZ_CODE) << 8) | 32'h4;
  localparam logic [WORD_W-1:0] AUX_RW_RST  = 32'h0001_8186;
  localparam logic [WORD_W-1:0] GUARD_VAL   = 32'd7;
  localparam logic [WORD_W-1:0] SPEED_RST   = 32'd7;

  typedef enum logic [4:0] {
    RK_NONE, RK_CFG, RK_BADADDR, RK_XL_BASE, RK_XL_LIM, RK_RMT_FAIL,
    RK_MEM_FAIL, RK_PTAG, RK_LTAG, RK_BMASK, RK_WINDOW, RK_SPEED, RK_DMA,
    RK_AUX_RO0, RK_AUX_RW, RK_NV_GUARD, RK_TMR_LOAD, RK_TMR_CNT, RK_AUX_RO1
  } reg_kind_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned AW      = 14,
  parameter int unsigned N_SPEED = 15,
  parameter int unsigned N_DMA   = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [AW-3:0]    waddr,
  output reg_kind_e        kind,
  output logic [IDX_W-1:0] idx
);

  localparam logic [AW-1:0] SPD_LO = AW'(SPEED_BASE);
  localparam logic [AW-1:0] SPD_HI = AW'(SPEED_BASE + 8 * (N_SPEED - 1));
  localparam logic [AW-1:0] DMA_LO = AW'(DMA_BASE);
  localparam logic [AW-1:0] DMA_HI = AW'(DMA_BASE + 8 * (N_DMA - 1));

  logic [AW-1:0] word;
  assign word = {waddr, 2'b00};

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    case (word)
      AW'(OFS_CFG):      kind = RK_CFG;
      AW'(OFS_BADADDR):  kind = RK_BADADDR;
      AW'(OFS_XL_BASE):  kind = RK_XL_BASE;
      AW'(OFS_XL_LIM):   kind = RK_XL_LIM;
      AW'(OFS_RMT_FAIL): kind = RK_RMT_FAIL;
      AW'(OFS_MEM_FAIL): kind = RK_MEM_FAIL;
      AW'(OFS_PTAG):     kind = RK_PTAG;
      AW'(OFS_LTAG):     kind = RK_LTAG;
      AW'(OFS_BMASK):    kind = RK_BMASK;
      AW'(OFS_WINDOW):   kind = RK_WINDOW;
      AW'(OFS_AUX_RO0):  kind = RK_AUX_RO0;
      AW'(OFS_AUX_RW):   kind = RK_AUX_RW;
      AW'(OFS_NV_GUARD): kind = RK_NV_GUARD;
      AW'(OFS_TMR_LOAD): kind = RK_TMR_LOAD;
      AW'(OFS_TMR_CNT):  kind = RK_TMR_CNT;
      AW'(OFS_AUX_RO1):  kind = RK_AUX_RO1;
      default: begin
        if (word >= SPD_LO && word <= SPD_HI && !word[2]) begin
          kind = RK_SPEED;
          idx  = IDX_W'((word - SPD_LO) >> 3);
        end else if (word >= DMA_LO && word <= DMA_HI && !word[2]) begin
          kind = RK_DMA;
          idx  = IDX_W'((word - DMA_LO) >> 3);
        end
      end
    endcase
  end

endmodule

// File: rtl/sysctl_lane.sv
module sysctl_lane
  import sysctl_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic [WORD_W-1:0] cur,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] picked
);

  logic [4:0] sh;
  assign sh = {lo, 3'b000};

  always_comb begin
    merged = cur;
    case (size)
      2'd0: merged[sh +: 8] = wdata[7:0];
      2'd1: begin
        if (lo[1]) merged[31:16] = wdata[15:0];
        else       merged[15:0]  = wdata[15:0];
      end
      default: merged = wdata;
    endcase
  end

  always_comb begin
    case (size)
      2'd0:    picked = {24'd0, cur[sh +: 8]};
      2'd1:    picked = lo[1] ? {16'd0, cur[31:16]} : {16'd0, cur[15:0]};
      default: picked = cur;
    endcase
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned       N       = 15,
  parameter int unsigned       IDX_W   = 5,
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);

  logic [N*WORD_W-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic              ent_en;
    logic [WORD_W-1:0] ent_q;
    assign ent_en = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     ent_q <= RST_VAL;
      else if (ent_en) ent_q <= wr_data;
    end
    assign flat[g*WORD_W +: WORD_W] = ent_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) rd_data = flat[i*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned AW         = 14,
  parameter int unsigned N_SPEED    = 15,
  parameter int unsigned N_DMA_CH   = 8,
  parameter int unsigned DMA_PER_CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tmr_load_stb,
  output logic [31:0]   tmr_load_val,
  output logic          tmr_count_stb
);

  localparam int unsigned N_DMA = N_DMA_CH * DMA_PER_CH;
  localparam int unsigned N_MAX = (N_DMA > N_SPEED) ? N_DMA : N_SPEED;
  localparam int unsigned IDX_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  reg_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] cur_word, merged, picked, spd_rd, dma_rd;
  logic              wr_fire, rd_fire;

  logic [WORD_W-1:0] cfg_q, xl_base_q, xl_lim_q, ptag_q, ltag_q, bmask_q;
  logic [WORD_W-1:0] win_q, aux_q, rdata_q, load_val_q;
  logic              load_stb_q, cnt_stb_q;

  logic cfg_en, xl_base_en, xl_lim_en, ptag_en, ltag_en, win_en, aux_en;
  logic bmask_en, spd_en, dma_en, load_stb_d, cnt_stb_d;
  logic [WORD_W-1:0] bmask_d;

  sysctl_decode #(.AW(AW), .N_SPEED(N_SPEED), .N_DMA(N_DMA), .IDX_W(IDX_W)) u_dec (
    .waddr (bus_addr[AW-1:2]),
    .kind  (kind),
    .idx   (idx)
  );

  sysctl_store #(.N(N_SPEED), .IDX_W(IDX_W), .RST_VAL(SPEED_RST)) u_speed (
    .clk(clk), .arst_n(arst_n), .wr_en(spd_en), .idx(idx),
    .wr_data(merged), .rd_data(spd_rd)
  );

  sysctl_store #(.N(N_DMA), .IDX_W(IDX_W), .RST_VAL('0)) u_dma (
    .clk(clk), .arst_n(arst_n), .wr_en(dma_en), .idx(idx),
    .wr_data(merged), .rd_data(dma_rd)
  );

  sysctl_lane u_lane (
    .size(bus_size), .lo(bus_addr[1:0]), .cur(cur_word),
    .wdata(bus_wdata), .merged(merged), .picked(picked)
  );

  // current content of the addressed word, as software sees it
  always_comb begin
    case (kind)
      RK_CFG:      cur_word = cfg_q;
      RK_XL_BASE:  cur_word = xl_base_q;
      RK_XL_LIM:   cur_word = xl_lim_q;
      RK_PTAG:     cur_word = ptag_q;
      RK_LTAG:     cur_word = ltag_q;
      RK_BMASK:    cur_word = bmask_q;
      RK_WINDOW:   cur_word = win_q;
      RK_SPEED:    cur_word = spd_rd;
      RK_DMA:      cur_word = dma_rd;
      RK_AUX_RW:   cur_word = aux_q;
      RK_NV_GUARD: cur_word = GUARD_VAL;
      RK_AUX_RO1:  cur_word = GUARD_VAL;
      default:     cur_word = '0;
    endcase
  end

  // next-state
  always_comb begin
    wr_fire    = bus_valid && bus_we;
    rd_fire    = bus_valid && !bus_we;
    cfg_en     = wr_fire && (kind == RK_CFG);
    xl_base_en = wr_fire && (kind == RK_XL_BASE);
    xl_lim_en  = wr_fire && (kind == RK_XL_LIM);
    ptag_en    = wr_fire && (kind == RK_PTAG);
    ltag_en    = wr_fire && (kind == RK_LTAG);
    win_en     = wr_fire && (kind == RK_WINDOW);
    aux_en     = wr_fire && (kind == RK_AUX_RW);
    spd_en     = wr_fire && (kind == RK_SPEED);
    dma_en     = wr_fire && (kind == RK_DMA);
    bmask_en   = (kind == RK_BMASK) &&
                 (wr_fire || (rd_fire && (bmask_q == '1)));
    bmask_d    = wr_fire ? (bmask_q | merged) : '0;
    load_stb_d = wr_fire && (kind == RK_TMR_LOAD);
    cnt_stb_d  = rd_fire && (kind == RK_TMR_CNT);
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cfg_q      <= CFG_RST;
      xl_base_q  <= '0;
      xl_lim_q   <= '0;
      ptag_q     <= '0;
      ltag_q     <= '0;
      bmask_q    <= '0;
      win_q      <= '0;
      aux_q      <= AUX_RW_RST;
      rdata_q    <= '0;
      load_val_q <= '0;
      load_stb_q <= 1'b0;
      cnt_stb_q  <= 1'b0;
    end else begin
      if (cfg_en)     cfg_q      <= merged;
      if (xl_base_en) xl_base_q  <= merged;
      if (xl_lim_en)  xl_lim_q   <= merged;
      if (ptag_en)    ptag_q     <= merged;
      if (ltag_en)    ltag_q     <= merged;
      if (win_en)     win_q      <= merged;
      if (aux_en)     aux_q      <= merged;
      if (bmask_en)   bmask_q    <= bmask_d;
      if (rd_fire)    rdata_q    <= picked;
      if (load_stb_d) load_val_q <= merged;
      load_stb_q <= load_stb_d;
      cnt_stb_q  <= cnt_stb_d;
    end
  end

  assign bus_rdata     = rdata_q;
  assign tmr_load_stb  = load_stb_q;
  assign tmr_load_val  = load_val_q;
  assign tmr_count_stb = cnt_stb_q;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          bus_valid,
  input logic          bus_we,
  input logic [1:0]    bus_size,
  input logic [AW-3:0] waddr,
  input logic [31:0]   bus_rdata,
  input logic          tmr_load_stb,
  input logic          tmr_count_stb
);

  localparam logic [AW-3:0] W_LOAD  = (AW-2)'('h228 >> 2);
  localparam logic [AW-3:0] W_CNT   = (AW-2)'('h230 >> 2);
  localparam logic [AW-3:0] W_UNMAP = (AW-2)'('h240 >> 2);

  logic rd, wr;
  assign rd = bus_valid && !bus_we;
  assign wr = bus_valid && bus_we;

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd |=> $stable(bus_rdata));

  p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd && bus_size == 2'd0) |=> (bus_rdata[31:8] == 24'd0));

  p_half_zext_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd && bus_size == 2'd1) |=> (bus_rdata[31:16] == 16'd0));

  p_high_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd && waddr >= W_UNMAP) |=> (bus_rdata == 32'd0));

  p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr && waddr == W_LOAD) |=> tmr_load_stb);

  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    !(wr && waddr == W_LOAD) |=> !tmr_load_stb);

  p_load_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd && waddr == W_LOAD) |=> (bus_rdata == 32'd0));

  p_count_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd && waddr == W_CNT) |=> (tmr_count_stb && bus_rdata == 32'd0));

  p_count_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    !(rd && waddr == W_CNT) |=> !tmr_count_stb);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_ns        (arst_n),
  .bus_valid     (bus_valid),
  .bus_we        (bus_we),
  .bus_size      (bus_size),
  .waddr         (bus_addr[AW-1:2]),
  .bus_rdata     (bus_rdata),
  .tmr_load_stb  (tmr_load_stb),
  .tmr_count_stb (tmr_count_stb)
);

// File: tb/sysctl_regfile_test.sv
`timescale 1ns/1ps
module sysctl_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_we;
  logic [1:0]  bus_size;
  logic [13:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, tmr_load_val;
  logic        tmr_load_stb, tmr_count_stb;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] mdl [0:4095];

  always #2 clk = ~clk;

  sysctl_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_load_stb(tmr_load_stb),
    .tmr_load_val(tmr_load_val), .tmr_count_stb(tmr_count_stb)
  );

  // 0 unmapped, 1 read/write, 2 read-only, 3 byte mask, 4 timer load, 5 timer count
  function automatic int kind_of(input logic [13:0] a);
    logic [13:0] w;
    w = {a[13:2], 2'b00};
    case (w)
      14'h000, 14'h018, 14'h020, 14'h048, 14'h050, 14'h060, 14'h210: return 1;
      14'h010, 14'h038, 14'h040, 14'h208, 14'h220, 14'h238: return 2;
      14'h058: return 3;
      14'h228: return 4;
      14'h230: return 5;
      default: ;
    endcase
    if (w >= 14'h070 && w <= 14'h0E0 && !w[2]) return 1;
    if (w >= 14'h100 && w <= 14'h1F8 && !w[2]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] reset_val(input logic [13:0] w);
    if (w == 14'h000) return 32'h104;
    if (w == 14'h210) return 32'h18186;
    if (w == 14'h220 || w == 14'h238) return 32'd7;
    if (w >= 14'h070 && w <= 14'h0E0 && !w[2]) return 32'd7;
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [13:0] a);
    int k;
    k = kind_of(a);
    if (k == 1 && a >= 14'h070 && a < 14'h0E8) return "R2";
    if (k == 1 && a >= 14'h100 && a < 14'h200) return "R3";
    if (k == 1) return "R11";
    if (k == 3) return "R6";
    if (k == 4) return "R9";
    if (k == 5) return "R10";
    return "R8";
  endfunction

  function automatic logic [31:0] m_read(input logic [13:0] a);
    int k;
    k = kind_of(a);
    if (k == 0 || k == 4 || k == 5) return 32'd0;
    return mdl[a[13:2]];
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] r;
    r = o;
    if (sz == 2'd0)      r[lo*8 +: 8] = d[7:0];
    else if (sz == 2'd1) r[lo[1]*16 +: 16] = d[15:0];
    else                 r = d;
    return r;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] sz,
                                       input logic [1:0] lo);
    if (sz == 2'd0) return (w >> (8 * lo)) & 32'hFF;
    if (sz == 2'd1) return lo[1] ? (w >> 16) : (w & 32'hFFFF);
    return w;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [1:0] sz,
                     input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [13:0] a, input string tag);
    logic [31:0] w, e;
    bit cnt;
    w   = m_read(a);
    e   = pick(w, sz, a[1:0]);
    cnt = (kind_of(a) == 5);
    acc(1'b0, sz, a, 32'd0);
    check(bus_rdata == e, tag, bus_rdata, e);
    check(tmr_count_stb == cnt && !tmr_load_stb, "R10",
          {30'd0, tmr_load_stb, tmr_count_stb}, {31'd0, cnt});
    if (kind_of(a) == 3 && w == 32'hFFFF_FFFF) mdl[a[13:2]] = 32'd0;
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [13:0] a, input logic [31:0] d);
    logic [31:0] o, mg;
    int k;
    k  = kind_of(a);
    o  = m_read(a);
    mg = merge(o, d, sz, a[1:0]);
    if (k == 1) mdl[a[13:2]] = mg;
    if (k == 3) mdl[a[13:2]] = o | mg;
    acc(1'b1, sz, a, d);
    check(tmr_load_stb == (k == 4) && !tmr_count_stb, "R9",
          {30'd0, tmr_count_stb, tmr_load_stb}, {31'd0, k == 4});
    if (k == 4) check(tmr_load_val == mg, "R9", tmr_load_val, mg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
    bus_size = 2'd2; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 4096; i++) mdl[i] = reset_val(14'(i * 4));
    repeat (4) @(negedge clk);
    check(bus_rdata == 0 && !tmr_load_stb && !tmr_count_stb, "R1", bus_rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset sweep of every word in the low window
    for (int i = 0; i < 256; i++) do_read(2'd2, 14'(i * 4), "R1");
    do_read(2'd2, 14'h3FFC, "R8");

    // patterned word writes everywhere, then read back (R2 R3 R8 R11)
    for (int i = 0; i < 256; i++)
      do_write(2'd2, 14'(i * 4), {16'(i * 4) ^ 16'hA5C3, ~16'(i * 4)});
    for (int i = 0; i < 256; i++) begin
      logic [13:0] a;
      a = 14'(i * 4);
      do_read(2'd2, a, tag_of(a));
    end
    do_write(2'd2, 14'h2000, 32'hDEAD_BEEF);
    do_read(2'd2, 14'h2000, "R8");

    // R5: narrow writes into several read/write words
    for (int j = 0; j < 4; j++) begin
      logic [13:0] a;
      case (j)
        0: a = 14'h000; 1: a = 14'h078; 2: a = 14'h148; default: a = 14'h210;
      endcase
      for (int k = 0; k < 4; k++) begin
        do_write(2'd0, a + 14'(k), 32'hFFFF_FF00 | 32'(8'h11 * (k + j + 1)));
        do_read(2'd2, a, "R5");
      end
      do_write(2'd1, a + 14'd2, 32'hFFFF_1234 + 32'(j));
      do_read(2'd2, a, "R5");
      do_write(2'd3, a, 32'hC0DE_0000 + 32'(j));
      do_write(2'd1, a, 32'h0000_9876);
      do_read(2'd2, a, "R5");
    end

    // R4: narrow reads of every lane
    for (int k = 0; k < 4; k++) do_read(2'd0, 14'h148 + 14'(k), "R4");
    do_read(2'd1, 14'h148, "R4");
    do_read(2'd1, 14'h14A, "R4");
    do_read(2'd0, 14'h211, "R4");
    // R4: read data holds across a write
    do_read(2'd2, 14'h018, "R4");
    keep = bus_rdata;
    do_write(2'd2, 14'h020, 32'h0BAD_F00D);
    check(bus_rdata == keep, "R4", bus_rdata, keep);

    // R8: narrow writes to read-only words have no effect
    do_write(2'd0, 14'h221, 32'h0000_00AB);
    do_read(2'd2, 14'h220, "R8");
    do_write(2'd1, 14'h23A, 32'h0000_5555);
    do_read(2'd2, 14'h238, "R8");
    do_write(2'd2, 14'h074, 32'h1234_5678);
    do_read(2'd2, 14'h074, "R2");
    do_write(2'd2, 14'h104, 32'h1234_5678);
    do_read(2'd2, 14'h104, "R3");

    // R6 R7: byte mask accumulation and self-clear
    do_write(2'd2, 14'h058, 32'h0000_0F0F);
    do_read(2'd2, 14'h058, "R6");
    do_read(2'd2, 14'h058, "R7");
    do_write(2'd0, 14'h05B, 32'h0000_00F0);
    do_write(2'd2, 14'h058, 32'h0000_0000);
    do_read(2'd2, 14'h058, "R6");
    do_write(2'd1, 14'h05A, 32'h0000_FFFF);
    do_write(2'd2, 14'h058, 32'h0000_FFFF);
    do_read(2'd2, 14'h058, "R7");
    do_read(2'd2, 14'h058, "R7");
    check(mdl[14'h058 >> 2] == 32'd0, "R7", mdl[14'h058 >> 2], 32'd0);
    do_write(2'd1, 14'h058, 32'h0000_00F0);
    do_read(2'd0, 14'h058, "R6");
    do_read(2'd2, 14'h058, "R6");

    // R9: timer reload strobe and value
    do_write(2'd2, 14'h228, 32'h1234_5678);
    do_write(2'd0, 14'h22A, 32'h0000_005A);
    do_write(2'd1, 14'h22A, 32'h0000_BEEF);
    do_read(2'd2, 14'h228, "R9");
    // R10: timer count read strobe
    do_read(2'd2, 14'h230, "R10");
    do_read(2'd0, 14'h233, "R10");
    do_write(2'd2, 14'h230, 32'hFFFF_FFFF);
    do_read(2'd2, 14'h230, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule